// File: doc/BRIEF.md
# Write-Protect Command Sequencer

This block sits between the bus write-cycle detector and the page buffer of a byte-wide non-volatile memory. Each captured write (address, data) arrives as a one-cycle strobe. The block keeps a protection flag and watches for command sequences formed from specific address/data pairs. It decides, one cycle later, whether each write goes on to the page buffer as data or is dropped. Command bytes never reach the buffer.

A three-write unlock sequence turns protection on if it was off. It also opens a single page-load window, in which every write passes. The window closes, and the part is locked again, as soon as the programming cycle starts (`prog_busy` high). A six-write disable sequence clears protection after a settle delay of `SETTLE_CYC` cycles. While protection is off and no sequence is in progress, ordinary writes pass straight through.

States: `ST_IDLE` (no match in progress), `ST_U1` (first key seen), `ST_U2` (second key seen), `ST_D3`, `ST_D4` and `ST_D5` (disable bytes three to five seen), `ST_WINDOW` (page load open) and `ST_SETTLE` (disable delay).

Transitions:
- ST_IDLE→ST_U1 on AA@5555.
- ST_U1→ST_U2 on 55@2AAA.
- ST_U2→ST_WINDOW on A0@5555.
- ST_U2→ST_D3 on 80@5555.
- ST_D3→ST_D4 on AA@5555.
- ST_D4→ST_D5 on 55@2AAA.
- ST_D5→ST_SETTLE on 20@5555.
- Any of ST_U1 to ST_D5 goes back to ST_IDLE on any other write (abort).
- ST_WINDOW→ST_IDLE when `prog_busy` is high.
- ST_SETTLE→ST_IDLE when the timer expires.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset `prot_on` is 0 (the `PROT_INIT` default), `window_open` is 0 and `pass_valid` is 0.
- R2: In ST_IDLE with protection off, a write that is not AA (hex) to address 5555 (hex) sets `pass_valid` in the next cycle, with `pass_addr`/`pass_data` equal to the write's address and data.
- R3: The writes AA@5555, 55@2AAA, A0@5555, in that order, set `prot_on` to 1 and `window_open` to 1. None of the three appears on `pass_valid`.
- R4: While `window_open` is 1, every write passes. The window closes on the first cycle in which `prog_busy` is high, and `prot_on` stays 1.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 clear `prot_on` `SETTLE_CYC` cycles after the last one. None of the six passes, and writes during the settle delay are dropped.
- R6: Command address matching compares only the low 15 address bits. Bit 15 may take either value.
- R7: A write that breaks a partial sequence returns the machine to ST_IDLE. That breaking write passes if protection is off and is dropped if it is on. The earlier bytes of the broken sequence never pass.
- R8: With protection on and no window open, every write is dropped.
- R9: A write that arrives while `prog_busy` is high outside the window is dropped and does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe of a captured bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_busy | input | 1 | Internal programming cycle in progress |
| pass_valid | output | 1 | Forwarded write to page buffer |
| pass_addr | output | ADDR_W | Forwarded address |
| pass_data | output | DATA_W | Forwarded data |
| prot_on | output | 1 | Protection flag |
| window_open | output | 1 | Page-load window after unlock is open |

## Verification
The assertions take for granted that `wr_valid` is a single-cycle strobe per bus write. They also assume `prog_busy` only rises after a page load, so a forwarded write always traces back to a strobe in the previous cycle. The stimulus drives every write as one strobe on a falling clock edge and releases it on the next. It raises `prog_busy` only in deliberate pulses, either to end the window or to tag a single write as arriving during programming. It waits out the full settle delay before testing unprotected traffic again.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_D3,
        ST_D4,
        ST_D5,
        ST_WINDOW,
        ST_SETTLE
    } seq_state_t;

    localparam logic [7:0] CODE_K1     = 8'hAA;
    localparam logic [7:0] CODE_K2     = 8'h55;
    localparam logic [7:0] CODE_UNLOCK = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_OFF    = 8'h20;
endpackage

// File: rtl/wp_cmd_match.sv
module wp_cmd_match #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 15,
    parameter logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit_k1,
    output logic              hit_k2,
    output logic              hit_unlock,
    output logic              hit_erase,
    output logic              hit_off
);
    import wp_seq_pkg::*;

    logic at_a;
    logic at_b;

    // upper address bits are not part of any command key
    assign at_a = (addr[CMP_W-1:0] == KEY_ADDR_A);
    assign at_b = (addr[CMP_W-1:0] == KEY_ADDR_B);

    assign hit_k1     = at_a && (data == DATA_W'(CODE_K1));
    assign hit_k2     = at_b && (data == DATA_W'(CODE_K2));
    assign hit_unlock = at_a && (data == DATA_W'(CODE_UNLOCK));
    assign hit_erase  = at_a && (data == DATA_W'(CODE_ERASE));
    assign hit_off    = at_a && (data == DATA_W'(CODE_OFF));
endmodule

// File: rtl/wp_settle_timer.sv
module wp_settle_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= LOAD;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LOAD)) else $error("timer count out of range"); // R5
endmodule

// File: rtl/wp_pass_stage.sv
module wp_pass_stage #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= fwd;
            if (fwd) begin
                out_addr <= in_addr;
                out_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CMP_W      = 15,
    parameter int SETTLE_CYC = 16,
    parameter bit PROT_INIT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_busy,
    output logic              pass_valid,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [DATA_W-1:0] pass_data,
    output logic              prot_on,
    output logic              window_open
);
    import wp_seq_pkg::*;

    seq_state_t state, nxt;
    logic prot_q;
    logic live, fwd, prot_set, prot_clr, tmr_start, tmr_done;
    logic hit_k1, hit_k2, hit_unlock, hit_erase, hit_off;

    wp_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_match (
        .addr(wr_addr), .data(wr_data),
        .hit_k1(hit_k1), .hit_k2(hit_k2), .hit_unlock(hit_unlock),
        .hit_erase(hit_erase), .hit_off(hit_off)
    );

    wp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done)
    );

    wp_pass_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pass (
        .clk(clk), .rst_n(rst_n), .fwd(fwd),
        .in_addr(wr_addr), .in_data(wr_data),
        .out_valid(pass_valid), .out_addr(pass_addr), .out_data(pass_data)
    );

    assign live = wr_valid && !prog_busy;

    // state and protect flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            prot_q <= PROT_INIT;
        end else begin
            state <= nxt;
            if (prot_set)      prot_q <= 1'b1;
            else if (prot_clr) prot_q <= 1'b0;
        end
    end

    // next state and per-write decisions
    always_comb begin
        nxt       = state;
        fwd       = 1'b0;
        prot_set  = 1'b0;
        prot_clr  = 1'b0;
        tmr_start = 1'b0;
        unique case (state)
            ST_IDLE: if (live) begin
                if (hit_k1) nxt = ST_U1;
                else        fwd = !prot_q;
            end
            ST_U1: if (live) begin
                if (hit_k2) nxt = ST_U2;
                else begin nxt = ST_IDLE; fwd = !prot_q; end
            end
            ST_U2: if (live) begin
                if (hit_unlock) begin
                    nxt      = ST_WINDOW;
                    prot_set = 1'b1;
                end else if (hit_erase) begin
                    nxt = ST_D3;
                end else begin
                    nxt = ST_IDLE;
                    fwd = !prot_q;
                end
            end
            ST_D3: if (live) begin
                if (hit_k1) nxt = ST_D4;
                else begin nxt = ST_IDLE; fwd = !prot_q; end
            end
            ST_D4: if (live) begin
                if (hit_k2) nxt = ST_D5;
                else begin nxt = ST_IDLE; fwd = !prot_q; end
            end
            ST_D5: if (live) begin
                if (hit_off) begin
                    nxt       = ST_SETTLE;
                    tmr_start = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                    fwd = !prot_q;
                end
            end
            ST_WINDOW: begin
                if (prog_busy)     nxt = ST_IDLE;
                else if (wr_valid) fwd = 1'b1;
            end
            ST_SETTLE: if (tmr_done) begin
                nxt      = ST_IDLE;
                prot_clr = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prot_on     = prot_q;
        window_open = (state == ST_WINDOW);
    end

    AST_PASS_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> $past(wr_valid)) else $error("pass without write"); // R2
    AST_PASS_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (pass_data == $past(wr_data) && pass_addr == $past(wr_addr)))
        else $error("forwarded write altered"); // R2
    AST_PROT_RISE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> window_open) else $error("protect set outside unlock"); // R3
    AST_UNLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_U2 && live && hit_unlock) |=> !pass_valid)
        else $error("unlock byte forwarded"); // R3
    AST_PROT_FALL_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> $past(state == ST_SETTLE)) else $error("protect cleared early"); // R5
    AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && wr_valid) |=> !pass_valid) else $error("write during settle"); // R5
    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && state != ST_WINDOW && wr_valid) |=> !pass_valid)
        else $error("write passed while locked"); // R8
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WINDOW && wr_valid && prog_busy) |=> (!pass_valid && $stable(state)))
        else $error("busy write acted on"); // R9
endmodule

// File: tb/tb_wp_cmd_seq.sv
module tb_wp_cmd_seq;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic prog_busy = 1'b0;
    logic pass_valid, prot_on, window_open;
    logic [AW-1:0] pass_addr;
    logic [DW-1:0] pass_data;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wp_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(SC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_busy(prog_busy), .pass_valid(pass_valid),
        .pass_addr(pass_addr), .pass_data(pass_data), .prot_on(prot_on),
        .window_open(window_open)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(string req, logic [AW-1:0] a, logic [DW-1:0] d,
                         logic busy, logic exp_pass);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; prog_busy = busy;
        @(negedge clk);
        wr_valid = 1'b0; prog_busy = 1'b0;
        chk(req, 32'(pass_valid), 32'(exp_pass));
        if (exp_pass) begin
            chk(req, 32'(pass_addr), 32'(a));
            chk(req, 32'(pass_data), 32'(d));
        end
    endtask

    task automatic t_reset;
        chk("R1", 32'(prot_on), 0);
        chk("R1", 32'(window_open), 0);
        chk("R1", 32'(pass_valid), 0);
    endtask

    task automatic t_plain;
        do_wr("R2", 16'h1234, 8'h5A, 1'b0, 1'b1);
        do_wr("R2", 16'h8000, 8'hFF, 1'b0, 1'b1);
        do_wr("R2", 16'h5555, 8'hA0, 1'b0, 1'b1);
    endtask

    task automatic t_abort_open;
        do_wr("R7", 16'h5555, 8'hAA, 1'b0, 1'b0);
        do_wr("R7", 16'h0100, 8'h11, 1'b0, 1'b1);
        chk("R7", 32'(prot_on), 0);
    endtask

    task automatic t_unlock;
        do_wr("R6", 16'hD555, 8'hAA, 1'b0, 1'b0);
        do_wr("R3", 16'h2AAA, 8'h55, 1'b0, 1'b0);
        do_wr("R3", 16'h5555, 8'hA0, 1'b0, 1'b0);
        chk("R3", 32'(prot_on), 1);
        chk("R3", 32'(window_open), 1);
    endtask

    task automatic t_window;
        do_wr("R4", 16'h0300, 8'h01, 1'b0, 1'b1);
        do_wr("R4", 16'h0301, 8'h02, 1'b0, 1'b1);
        @(negedge clk); prog_busy = 1'b1;
        @(negedge clk); prog_busy = 1'b0;
        chk("R4", 32'(window_open), 0);
        chk("R4", 32'(prot_on), 1);
        do_wr("R8", 16'h0302, 8'h03, 1'b0, 1'b0);
    endtask

    task automatic t_abort_locked;
        do_wr("R7", 16'h5555, 8'hAA, 1'b0, 1'b0);
        do_wr("R7", 16'h2AAA, 8'h55, 1'b0, 1'b0);
        do_wr("R7", 16'h5555, 8'h33, 1'b0, 1'b0);
        chk("R7", 32'(window_open), 0);
        chk("R7", 32'(prot_on), 1);
    endtask

    task automatic t_busy;
        do_wr("R9", 16'h5555, 8'hAA, 1'b1, 1'b0);
        do_wr("R9", 16'h2AAA, 8'h55, 1'b0, 1'b0);
        do_wr("R9", 16'h5555, 8'hA0, 1'b0, 1'b0);
        chk("R9", 32'(window_open), 0);
    endtask

    task automatic t_disable;
        do_wr("R5", 16'h5555, 8'hAA, 1'b0, 1'b0);
        do_wr("R5", 16'hAAAA, 8'h55, 1'b0, 1'b0);
        do_wr("R5", 16'h5555, 8'h80, 1'b0, 1'b0);
        do_wr("R5", 16'h5555, 8'hAA, 1'b0, 1'b0);
        do_wr("R5", 16'h2AAA, 8'h55, 1'b0, 1'b0);
        do_wr("R5", 16'h5555, 8'h20, 1'b0, 1'b0);
        chk("R5", 32'(prot_on), 1);
        do_wr("R5", 16'h0400, 8'h44, 1'b0, 1'b0);
        chk("R5", 32'(prot_on), 1);
        repeat (SC + 2) @(negedge clk);
        chk("R5", 32'(prot_on), 0);
        do_wr("R2", 16'h0401, 8'h45, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_abort_open();
        t_unlock();
        t_window();
        t_abort_locked();
        t_busy();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule